// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a processor core and a data memory that is one 32-bit word wide. Memory is byte addressed, every address names a single byte, and a word is held with its most significant byte at the lowest address. The unit adds a base register to a signed displacement counted in bytes. From the sum it produces the word address sent to memory and the position of the byte inside that word.

On a store the unit copies the byte or halfword into every lane it could occupy. It raises only the byte strobes that belong to the addressed bytes. On a load it takes the word returned by memory and picks out the addressed byte or halfword. The field is then sign-extended or zero-extended to a full register value. Halfword and word accesses that do not sit on their natural boundary are flagged, and the flag suppresses every write strobe.

The block is purely combinational. It has no clock and no state.

Top module: `be_lane_unit`

## Requirements
- R1: The effective address is `base_addr` plus `disp` sign-extended to 32 bits, modulo 2^32. `word_addr` equals bits 31:2 of that sum. The byte offset is bits 1:0.
- R2: `acc_size` encodes 00 as byte, 01 as halfword, and 10 or 11 as word. A byte store at offset k (0..3) raises only strobe bit 3-k. `mem_wdata` carries the low byte of `wr_data` in all four lanes.
- R3: A halfword store at offset 0 raises strobes 4'b1100, and at offset 2 it raises 4'b0011. `mem_wdata` carries the low halfword of `wr_data` in both halves.
- R4: An aligned word store raises strobes 4'b1111, and `mem_wdata` equals `wr_data`.
- R5: `misaligned` is 1 for a halfword access with offset bit 0 set, or for a word access with either offset bit set, whatever the value of `wr_en`. While it is 1, `byte_en` is 4'b0000.
- R6: While `wr_en` is 0, `byte_en` is 4'b0000. Memory therefore stays unchanged.
- R7: A byte load at offset k returns bits (31-8k) down to (24-8k) of `rd_word`. The value is sign-extended when `ld_signed` is 1 and zero-extended when it is 0.
- R8: A halfword load returns `rd_word[31:16]` at offset 0 and `rd_word[15:0]` at offset 2. It is extended under the same `ld_signed` rule.
- R9: An aligned word load returns `rd_word` unchanged. Any misaligned load returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_addr | input | 32 | Base register value |
| disp | input | DISP_W (16) | Signed byte displacement |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| wr_en | input | 1 | 1 for a store, 0 for a load |
| ld_signed | input | 1 | 1 for sign extension of sub-word loads |
| wr_data | input | 32 | Store data, right-justified |
| rd_word | input | 32 | Word returned by memory |
| word_addr | output | 30 | Word address for memory |
| byte_en | output | 4 | Byte write strobes, bit 3 is the lowest byte address |
| mem_wdata | output | 32 | Store data placed in lanes |
| ld_result | output | 32 | Extended load value |
| misaligned | output | 1 | Alignment fault flag |

## Verification
The bench drives a small byte-array memory and checks every size, offset and sign combination byte by byte against big-endian order. A design with mirrored lanes would write the byte to the wrong address and read back the neighbour. A design with the sign rules swapped would return 0xFF.. where zeros belong, because the bench's test bytes have the top bit both set and clear. A negative displacement that crosses a word boundary catches a design that zero-extends the displacement. Misaligned halfword and word stores must leave every byte of memory untouched, and a size code of 11 must behave exactly like a word access.

// File: rtl/be_lane_unit.sv
module be_lane_unit #(
  parameter int DISP_W = 16
) (
  input  logic [31:0]       base_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        acc_size,
  input  logic              wr_en,
  input  logic              ld_signed,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       rd_word,
  output logic [29:0]       word_addr,
  output logic [3:0]        byte_en,
  output logic [31:0]       mem_wdata,
  output logic [31:0]       ld_result,
  output logic              misaligned
);
  localparam int EXT_W = 32 - DISP_W;

  logic [31:0] eff_addr;
  logic [1:0]  off;
  logic        is_byte, is_half, is_word;
  logic [3:0]  lane_mask;
  logic [4:0]  shamt;
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  assign eff_addr  = base_addr + {{EXT_W{disp[DISP_W-1]}}, disp};
  assign off       = eff_addr[1:0];
  assign word_addr = eff_addr[31:2];

  assign is_byte = (acc_size == 2'b00);
  assign is_half = (acc_size == 2'b01);
  assign is_word = acc_size[1];

  assign misaligned = (is_half & off[0]) | (is_word & (|off));

  always_comb begin
    if (is_byte)      lane_mask = 4'b1000 >> off;
    else if (is_half) lane_mask = off[1] ? 4'b0011 : 4'b1100;
    else              lane_mask = 4'b1111;
  end

  assign byte_en = (wr_en && !misaligned) ? lane_mask : 4'b0000;

  always_comb begin
    if (is_byte)      mem_wdata = {4{wr_data[7:0]}};
    else if (is_half) mem_wdata = {2{wr_data[15:0]}};
    else              mem_wdata = wr_data;
  end

  assign shamt    = {~off, 3'b000};
  assign sel_byte = 8'(rd_word >> shamt);
  assign sel_half = off[1] ? rd_word[15:0] : rd_word[31:16];

  always_comb begin
    if (misaligned)
      ld_result = 32'd0;
    else if (is_byte)
      ld_result = {{24{ld_signed & sel_byte[7]}}, sel_byte};
    else if (is_half)
      ld_result = {{16{ld_signed & sel_half[15]}}, sel_half};
    else
      ld_result = rd_word;
  end
endmodule

// File: rtl/be_lane_chk.sv
module be_lane_chk #(
  parameter int DISP_W = 16
) (
  input logic [31:0]       base_addr,
  input logic [DISP_W-1:0] disp,
  input logic [1:0]        acc_size,
  input logic              wr_en,
  input logic              ld_signed,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_word,
  input logic [29:0]       word_addr,
  input logic [3:0]        byte_en,
  input logic [31:0]       mem_wdata,
  input logic [31:0]       ld_result,
  input logic              misaligned
);
  logic [31:0] ea_c;
  assign ea_c = base_addr + 32'(signed'(disp));

  always_comb begin
    p_word_addr_r1: assert (word_addr == ea_c[31:2]);
    if (wr_en && !misaligned && acc_size == 2'b00)
      p_byte_one_lane_r2: assert ($countones(byte_en) == 1 && mem_wdata[31:24] == wr_data[7:0]);
    if (wr_en && !misaligned && acc_size == 2'b01)
      p_half_two_lanes_r3: assert ($countones(byte_en) == 2 && mem_wdata[15:0] == wr_data[15:0]);
    if (wr_en && !misaligned && acc_size[1])
      p_word_all_lanes_r4: assert (byte_en == 4'b1111 && mem_wdata == wr_data);
    if (misaligned)
      p_misalign_no_strobe_r5: assert (byte_en == 4'b0000 && acc_size != 2'b00);
    if (!wr_en)
      p_load_no_strobe_r6: assert (byte_en == 4'b0000);
    if (!misaligned && acc_size == 2'b00)
      p_byte_ext_r7: assert (ld_result[31:8] == (ld_signed && ld_result[7] ? 24'hFFFFFF : 24'h0));
    if (!misaligned && acc_size == 2'b01)
      p_half_ext_r8: assert (ld_result[31:16] == (ld_signed && ld_result[15] ? 16'hFFFF : 16'h0));
    if (!misaligned && acc_size[1])
      p_word_load_r9: assert (ld_result == rd_word);
    if (misaligned)
      p_misalign_zero_r9: assert (ld_result == 32'd0);
  end
endmodule

bind be_lane_unit be_lane_chk #(.DISP_W(DISP_W)) u_chk (.*);

// File: tb/sim_be_lane_unit.sv
module sim_be_lane_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] base_addr, wr_data, rd_word;
  logic [15:0] disp;
  logic [1:0]  acc_size;
  logic        wr_en, ld_signed;
  logic [29:0] word_addr;
  logic [3:0]  byte_en;
  logic [31:0] mem_wdata, ld_result;
  logic        misaligned;

  be_lane_unit u0 (.*);

  logic [7:0] mem [64];
  int errs = 0, nchk = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ea_of(logic [31:0] b, logic [15:0] d);
    logic [31:0] s = b + {{16{d[15]}}, d};
    return int'(s);
  endfunction

  task automatic do_store(logic [31:0] b, logic [15:0] d, logic [1:0] sz, logic [31:0] dat, bit en);
    logic [7:0] snap [64];
    int ea = ea_of(b, d);
    int off = ea & 3;
    bit mis = (sz == 2'b01 && off[0]) || (sz[1] && off != 0);
    logic [3:0] exp_be;
    foreach (snap[i]) snap[i] = mem[i];
    if (sz == 2'b00)      exp_be = 4'b1000 >> off;
    else if (sz == 2'b01) exp_be = (off >= 2) ? 4'b0011 : 4'b1100;
    else                  exp_be = 4'b1111;
    if (mis || !en) exp_be = 4'b0000;
    @(negedge clk);
    base_addr = b; disp = d; acc_size = sz; wr_data = dat; wr_en = en; ld_signed = 0;
    #1;
    chk("R1 word_addr", 32'(word_addr), 32'(ea) >> 2);
    chk(mis ? "R5 misaligned" : "R5 aligned flag", 32'(misaligned), 32'(mis));
    chk(!en ? "R6 strobes" : (sz == 0 ? "R2 strobes" : (sz == 1 ? "R3 strobes" : "R4 strobes")),
        32'(byte_en), 32'(exp_be));
    for (int i = 0; i < 4; i++)
      if (byte_en[i]) mem[(word_addr * 4 + (3 - i)) & 63] = mem_wdata[8*i +: 8];
    if (!mis && en) begin
      if (sz == 2'b00) snap[ea & 63] = dat[7:0];
      else if (sz == 2'b01) begin snap[ea & 63] = dat[15:8]; snap[(ea + 1) & 63] = dat[7:0]; end
      else for (int k = 0; k < 4; k++) snap[(ea + k) & 63] = dat[31 - 8*k -: 8];
    end
    for (int i = 0; i < 64; i++)
      if (mem[i] !== snap[i])
        chk(!en ? "R6 memory" : (mis ? "R5 memory" : (sz == 0 ? "R2 memory" : (sz == 1 ? "R3 memory" : "R4 memory"))),
            32'(mem[i]), 32'(snap[i]));
    nchk++;
  endtask

  task automatic do_load(logic [31:0] b, logic [15:0] d, logic [1:0] sz, bit sgn);
    int ea = ea_of(b, d);
    int w = ea & 60;
    int off = ea & 3;
    bit mis = (sz == 2'b01 && off[0]) || (sz[1] && off != 0);
    logic [31:0] exp;
    logic [7:0]  bb;
    logic [15:0] hh;
    bb = mem[ea & 63];
    hh = {mem[ea & 63], mem[(ea + 1) & 63]};
    if (mis) exp = 0;
    else if (sz == 2'b00) exp = sgn ? {{24{bb[7]}}, bb} : {24'h0, bb};
    else if (sz == 2'b01) exp = sgn ? {{16{hh[15]}}, hh} : {16'h0, hh};
    else exp = {mem[w], mem[w+1], mem[w+2], mem[w+3]};
    @(negedge clk);
    base_addr = b; disp = d; acc_size = sz; wr_en = 0; ld_signed = sgn;
    rd_word = {mem[w], mem[w+1], mem[w+2], mem[w+3]};
    #1;
    chk(mis ? "R9 misaligned load" : (sz == 0 ? "R7 byte load" : (sz == 1 ? "R8 half load" : "R9 word load")),
        ld_result, exp);
    chk("R6 load strobes", 32'(byte_en), 32'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    base_addr = 0; disp = 0; acc_size = 0; wr_en = 0; ld_signed = 0; wr_data = 32'hFFFF_FFFF; rd_word = 0;
    #1;
    chk("R6 idle strobes", 32'(byte_en), 0);
    chk("R1 idle addr", 32'(word_addr), 0);
  endtask

  task automatic t_bytes;
    for (int o = 0; o < 4; o++) begin
      do_store(32'd8, 16'(o), 2'b00, 32'h1234_5680 + 32'(o * 33), 1);
      do_load(32'd8, 16'(o), 2'b00, 1);
      do_load(32'd8, 16'(o), 2'b00, 0);
    end
  endtask

  task automatic t_halves;
    for (int o = 0; o < 4; o++) begin
      do_store(32'd20, 16'(o), 2'b01, 32'hABCD_8E71 ^ 32'(o << 13), 1);
      do_load(32'd20, 16'(o & 2), 2'b01, 1);
      do_load(32'd20, 16'(o & 2), 2'b01, 0);
      do_load(32'd20, 16'(o), 2'b01, 1);
    end
  endtask

  task automatic t_words;
    for (int o = 0; o < 4; o++) begin
      do_store(32'd32, 16'(o), 2'b10, 32'hC0DE_0001 + 32'(o), 1);
      do_load(32'd32, 16'(o), 2'b10, 0);
    end
    do_store(32'd36, 16'd0, 2'b11, 32'h8765_4321, 1);
    do_load(32'd36, 16'd0, 2'b11, 1);
    do_store(32'd37, 16'd0, 2'b11, 32'h1111_1111, 1);
  endtask

  task automatic t_negdisp;
    do_store(32'd50, 16'hFFF9, 2'b00, 32'h0000_00F3, 1);
    do_load(32'd50, 16'hFFF9, 2'b00, 1);
    do_store(32'd50, 16'hFFF8, 2'b01, 32'h0000_7F80, 1);
    do_load(32'd50, 16'hFFF8, 2'b01, 1);
  endtask

  task automatic t_noweren;
    do_store(32'd12, 16'd0, 2'b10, 32'hDEAD_BEEF, 0);
    do_store(32'd13, 16'd0, 2'b00, 32'hDEAD_BEEF, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 129);
    t_idle();
    t_bytes();
    t_halves();
    t_words();
    t_negdisp();
    t_noweren();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end
endmodule